// File: doc/BRIEF.md
# Dual-Modulus Synthesiser Divider Counters

This block is the digital divider core of a frequency synthesiser that works with an external two-modulus prescaler (dividing by P or by P+1). It holds three counters. The first is a programmable reference divider, clocked by the oscillator input, that emits one reference pulse per programmed ratio. The other two form a pulse-swallow pair, clocked by the prescaler output. One counter sets the main period of M prescaler cycles. The other counts A of those cycles. Together they drive the modulus control output, so the overall division from the prescaler input to the main pulse is M·P + A.

A host loads the three ratios as 4-bit words. Each word carries a 3-bit word address and is latched on the rising edge of a strobe, but only while program enable is high. The words go into shadow registers. Each counter copies its shadow value only when it reloads, so a ratio never changes partway through a count cycle. All outputs change on the rising edge of their own counter clock. The one exception is the reference bypass case, where the oscillator clock is passed straight through.

Top module: `dualmod_synth_counters`

## Requirements
- R1: While reset is low, mod_ctl and main_pulse are 0. All ratios reset to 0, so ref_pulse follows osc_clk (high while osc_clk is high, low while it is low).
- R2: Word addresses 0, 1 and 2 hold the 11-bit reference ratio: address 0 carries bits 3:0, address 1 bits 7:4 and address 2 bits 10:8. Data bit 3 of address 2 is ignored.
- R3: Addresses 3, 4 and 5 hold the 10-bit M ratio: bits 3:0, 7:4 and 9:8 in that order, with data bits 3:2 of address 5 ignored. Addresses 6 and 7 hold the 7-bit A ratio: bits 3:0 and 6:4, with data bit 3 of address 7 ignored.
- R4: A strobe rising edge while prog_en is 0 writes nothing.
- R5: For a reference ratio R of 2 or more, ref_pulse is high for exactly one osc_clk period out of every R.
- R6: For a reference ratio of 0 or 1, ref_pulse equals osc_clk.
- R7: main_pulse is high for one pre_clk period at each main reload. Reloads occur every M pre_clk periods, and an M ratio of 0 acts as 1.
- R8: After each main reload, mod_ctl is high (meaning divide by P+1) for the first A pre_clk periods and low (divide by P) for the rest of the M periods. The total ratio is therefore M·P + A.
- R9: When A is greater than or equal to the effective M, A is saturated at M and mod_ctl stays high for all M periods.
- R10: A ratio written during a count cycle takes effect only from the next reload of that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock for the reference divider |
| pre_clk | input | 1 | Prescaler output clock for the M/A counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Program enable; a strobe writes only while this is high |
| strobe | input | 1 | Word latch strobe, active on its rising edge |
| word_sel | input | 3 | Word address 0-7 |
| data | input | 4 | Programming nibble |
| mod_ctl | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| ref_pulse | output | 1 | Reference-divided pulse |
| main_pulse | output | 1 | Main-divided pulse |

## Verification
The pulse-swallow pair is swept over every M from 1 to 6 against every A from 0 to 7. Each combination checks the period length, the count and prefix placement of mod_ctl high periods, and the summed ratio with P = 8. The sweep separates the swallow case (A < M) from saturation (A ≥ M). Full-width word patterns with junk in the top bits check the nibble mapping and the masking of unused bits. A write with prog_en low and a write in the middle of a cycle check that ratios change only through enabled strobes, and only at reload. The reference divider is swept from 2 to 9, checked in its 0 and 1 bypass modes, and tried at a large ratio spread over all three words.

// File: rtl/dualmod_synth_counters.sv
module dualmod_synth_counters #(
  parameter int REF_W = 11,
  parameter int M_W   = 10,
  parameter int A_W   = 7
) (
  input  logic       osc_clk,
  input  logic       pre_clk,
  input  logic       rst_n,
  input  logic       prog_en,
  input  logic       strobe,
  input  logic [2:0] word_sel,
  input  logic [3:0] data,
  output logic       mod_ctl,
  output logic       ref_pulse,
  output logic       main_pulse
);

  localparam int M_BASE = 3;
  localparam int A_BASE = 6;

  logic [REF_W-1:0] ref_sh, ref_cnt, ref_cur;
  logic [M_W-1:0]   m_sh, m_cnt, m_eff;
  logic [A_W-1:0]   a_sh, a_cnt, a_eff;
  logic             ref_q, main_q;

  always_ff @(posedge strobe or negedge rst_n)
    if (!rst_n) begin
      ref_sh <= '0;
      m_sh   <= '0;
      a_sh   <= '0;
    end else if (prog_en) begin
      for (int i = 0; i < REF_W; i++)
        if (word_sel == 3'(i / 4)) ref_sh[i] <= data[i % 4];
      for (int i = 0; i < M_W; i++)
        if (word_sel == 3'(M_BASE + i / 4)) m_sh[i] <= data[i % 4];
      for (int i = 0; i < A_W; i++)
        if (word_sel == 3'(A_BASE + i / 4)) a_sh[i] <= data[i % 4];
    end

  wire ref_bypass = (ref_cur <= REF_W'(1));

  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) begin
      ref_cnt <= '0;
      ref_cur <= '0;
      ref_q   <= 1'b0;
    end else if (ref_cnt == '0) begin
      ref_cur <= ref_sh;
      ref_cnt <= (ref_sh <= REF_W'(1)) ? '0 : ref_sh - REF_W'(1);
      ref_q   <= 1'b1;
    end else begin
      ref_cnt <= ref_cnt - REF_W'(1);
      ref_q   <= 1'b0;
    end

  assign ref_pulse = ref_bypass ? osc_clk : ref_q;

  assign m_eff = (m_sh == '0) ? M_W'(1) : m_sh;
  assign a_eff = (M_W'(a_sh) >= m_eff) ? A_W'(m_eff) : a_sh;

  always_ff @(posedge pre_clk or negedge rst_n)
    if (!rst_n) begin
      m_cnt  <= '0;
      a_cnt  <= '0;
      main_q <= 1'b0;
    end else if (m_cnt == '0) begin
      m_cnt  <= m_eff - M_W'(1);
      a_cnt  <= a_eff;
      main_q <= 1'b1;
    end else begin
      m_cnt  <= m_cnt - M_W'(1);
      if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
      main_q <= 1'b0;
    end

  assign mod_ctl    = (a_cnt != '0);
  assign main_pulse = main_q;

  assert_a_within_m_R9: assert property (@(posedge pre_clk) disable iff (!rst_n)
    ({1'b0, M_W'(a_cnt)} <= {1'b0, m_cnt} + (M_W+1)'(1)))
    else $error("A count exceeds remaining M periods");

  assert_mod_rise_at_reload_R8: assert property (@(posedge pre_clk) disable iff (!rst_n)
    $rose(mod_ctl) |-> main_q)
    else $error("modulus control rose outside a reload");

  assert_main_single_R7: assert property (@(posedge pre_clk) disable iff (!rst_n)
    (main_q && m_cnt != '0) |=> !main_q)
    else $error("main pulse wider than one period");

  assert_ref_single_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ref_q && ref_cur > REF_W'(1)) |=> !ref_q)
    else $error("reference pulse wider than one period");

endmodule

// File: tb/dualmod_synth_counters_tb.sv
module dualmod_synth_counters_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8;

  logic osc_clk = 0, pre_clk = 0, rst_n = 0;
  logic prog_en = 0, strobe = 0;
  logic [2:0] word_sel = '0;
  logic [3:0] data = '0;
  logic mod_ctl, ref_pulse, main_pulse;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  always #(CLK_PERIOD/2) pre_clk = ~pre_clk;

  dualmod_synth_counters u_dut (
    .osc_clk(osc_clk), .pre_clk(pre_clk), .rst_n(rst_n),
    .prog_en(prog_en), .strobe(strobe), .word_sel(word_sel), .data(data),
    .mod_ctl(mod_ctl), .ref_pulse(ref_pulse), .main_pulse(main_pulse));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(bit en, int sel, logic [3:0] d);
    @(negedge pre_clk);
    prog_en = en; word_sel = 3'(sel); data = d;
    #1 strobe = 1;
    #1 strobe = 0;
    prog_en = 0;
  endtask

  task automatic prog_ma(int m, int a);
    logic [11:0] mv = 12'(m);
    logic [7:0]  av = 8'(a);
    wr(1, 5, mv[11:8]); wr(1, 4, mv[7:4]); wr(1, 3, mv[3:0]);
    wr(1, 7, av[7:4]);  wr(1, 6, av[3:0]);
  endtask

  task automatic prog_ref(int r);
    logic [11:0] rv = 12'(r);
    wr(1, 2, rv[11:8]); wr(1, 1, rv[7:4]); wr(1, 0, rv[3:0]);
  endtask

  task automatic sync_main(string req);
    int n = 0;
    @(negedge pre_clk);
    while (!main_pulse && n < 5000) begin @(negedge pre_clk); n++; end
    if (n >= 5000) chk(0, req, 0, 1);
  endtask

  task automatic meas_main(output int len, output int highs, output int tot, output bit pre);
    bit seen_low = 0;
    len = 0; highs = 0; tot = 0; pre = 1;
    do begin
      if (mod_ctl) begin highs++; tot += P + 1; if (seen_low) pre = 0; end
      else begin seen_low = 1; tot += P; end
      len++;
      @(negedge pre_clk);
    end while (!main_pulse && len < 4000);
  endtask

  task automatic check_ma(int m, int a, string req);
    int meff, aeff, len, highs, tot;
    bit pre;
    meff = (m == 0) ? 1 : m;
    aeff = (a >= meff) ? meff : a;
    sync_main(req); sync_main(req);
    meas_main(len, highs, tot, pre);
    chk(len == meff, "R7 period", len, meff);
    chk(highs == aeff && pre, req, highs, aeff);
    chk(tot == meff * P + aeff, "R8 total ratio", tot, meff * P + aeff);
  endtask

  task automatic sync_ref();
    int n = 0;
    @(negedge osc_clk);
    while (!ref_pulse && n < 5000) begin @(negedge osc_clk); n++; end
    if (n >= 5000) chk(0, "R5 ref sync", 0, 1);
  endtask

  task automatic check_ref(int r, string req);
    int len = 0;
    sync_ref(); sync_ref();
    do begin len++; @(negedge osc_clk); end while (!ref_pulse && len < 4000);
    chk(len == r, req, len, r);
  endtask

  task automatic check_bypass(string req);
    repeat (3) begin
      @(posedge osc_clk); #1 chk(ref_pulse == 1, req, ref_pulse, 1);
      @(negedge osc_clk); #1 chk(ref_pulse == 0, req, ref_pulse, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int len, highs, tot;
    bit pre;
    repeat (3) @(negedge pre_clk);
    chk(mod_ctl == 0, "R1 mod_ctl in reset", mod_ctl, 0);
    chk(main_pulse == 0, "R1 main_pulse in reset", main_pulse, 0);
    check_bypass("R1 ref follows clock in reset");
    @(negedge pre_clk); rst_n = 1;

    check_ma(0, 0, "R7 M=0 acts as 1");

    for (int m = 1; m <= 6; m++)
      for (int a = 0; a <= 7; a++) begin
        prog_ma(m, a);
        check_ma(m, a, (a >= m) ? "R9 saturated A" : "R8 swallow A");
      end

    wr(1, 5, 4'hE); wr(1, 4, 4'hA); wr(1, 3, 4'h5);
    wr(1, 7, 4'hF); wr(1, 6, 4'h3);
    check_ma(12'h2A5, 8'h73, "R3 nibble map M/A");

    wr(0, 5, 4'h0); wr(0, 4, 4'h0); wr(0, 3, 4'h2); wr(0, 6, 4'h0); wr(0, 7, 4'h0);
    check_ma(12'h2A5, 8'h73, "R4 disabled write ignored");

    prog_ma(20, 5);
    sync_main("R10"); sync_main("R10");
    fork
      begin repeat (3) @(negedge pre_clk); prog_ma(4, 1); end
    join_none
    meas_main(len, highs, tot, pre);
    chk(len == 20, "R10 current period kept", len, 20);
    chk(highs == 5, "R10 current A kept", highs, 5);
    meas_main(len, highs, tot, pre);
    chk(len == 4, "R10 new period", len, 4);
    chk(highs == 1, "R10 new A", highs, 1);

    for (int r = 2; r <= 9; r++) begin
      prog_ref(r);
      check_ref(r, "R5 reference ratio");
    end

    prog_ref(1);
    repeat (30) @(negedge osc_clk);
    check_bypass("R6 ratio 1 bypass");
    prog_ref(0);
    repeat (5) @(negedge osc_clk);
    check_bypass("R6 ratio 0 bypass");

    wr(1, 2, 4'hD); wr(1, 1, 4'hA); wr(1, 0, 4'h3);
    check_ref(12'h5A3, "R2 reference nibble map");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule